// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a synchronous request port to an external byte-wide asynchronous static RAM with 128K locations. The user side offers a request with a 17-bit address, a write flag and a data byte, using valid/ready. The controller then drives the RAM's address bus, its active-low select, its active-high select, its active-low write strobe and its active-low output strobe. It also drives the shared data bus during writes. Read data comes back on a registered port that carries a one-cycle valid pulse.

All timing is set by counting clock cycles. Two parameters set the clock period and the speed grade of the part, which is 10, 12 or 15 ns. Each wait is the ceiling of the needed time over the clock period, plus one cycle of margin. The needed time is the access time for reads and write pulses, and the bus-release time for the turnaround before a write that follows a read. With the defaults (4 ns clock, 10 ns grade), RD_CYC = WP_CYC = 4 and TA_CYC = 3. The bus-release time is 6 ns for the 10 and 12 ns grades and 7 ns for the 15 ns grade.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held, and just after it, req_ready is 1, rsp_valid is 0, sram_ce1_n is 1, sram_ce2 is 0, sram_we_n is 1 and sram_oe_n is 1.
- R2: Whenever sram_oe_n is 0, sram_ce1_n is 0, sram_ce2 is 1 and sram_we_n is 1. Each read keeps sram_oe_n low for exactly RD_CYC+1 cycles.
- R3: A read gives exactly one rsp_valid pulse, one cycle wide, RD_CYC+1 clock edges after the edge that accepted it. rsp_rdata carries the byte last written to that address. Writes never raise rsp_valid.
- R4: A write holds sram_we_n at 0 for exactly WP_CYC cycles. During that time sram_ce1_n is 0, sram_ce2 is 1 and sram_oe_n is 1.
- R5: Address and write data sit on the bus with the RAM selected for one cycle before sram_we_n falls. They stay unchanged, with the RAM still selected, in the cycle after sram_we_n rises.
- R6: A write that follows a read sees at least TA_CYC+1 cycles with every strobe inactive, counted from the rise of sram_oe_n to the first cycle of the write. That is one idle cycle plus TA_CYC turnaround cycles.
- R7: A write that does not follow a read selects the RAM in the first cycle after the accepting edge.
- R8: req_ready is 1 only while idle. It falls after an accepting edge. It returns 1 after RD_CYC+1 cycles for a read, or after WP_CYC+2 cycles for a write (plus TA_CYC after a read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read byte |
| sram_addr | output | 17 | RAM address bus |
| sram_ce1_n | output | 1 | Active-low select |
| sram_ce2 | output | 1 | Active-high select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output strobe |
| sram_dq | inout | 8 | Shared data bus, driven only during writes |

## Verification
The bench's memory model returns a garbage byte until the read strobes have been active for the grade's access time. A controller that captures too early therefore returns 0xEE instead of the stored byte. A write issued right after a read is watched for its strobe-free gap. A design that skips or shortens the turnaround would start driving the bus while the RAM may still be driving it. The edges of the write strobe are checked against the address and data one cycle before and one cycle after, which catches designs that move the address inside the setup or hold margin. The extreme addresses 0 and 0x1FFFF are written and read back to expose a truncated address path.

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int AW       = 17,
  parameter int DW       = 8,
  parameter int CLK_NS   = 4,
  parameter int GRADE_NS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce1_n,
  output logic          sram_ce2,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  inout  wire  [DW-1:0] sram_dq
);
  localparam int HZ_NS  = (GRADE_NS >= 15) ? 7 : 6;
  localparam int ACC_NS = (GRADE_NS > 6) ? GRADE_NS : 6;
  localparam int RD_CYC = (ACC_NS + CLK_NS - 1) / CLK_NS + 1;
  localparam int WP_CYC = (GRADE_NS + CLK_NS - 1) / CLK_NS + 1;
  localparam int TA_CYC = (HZ_NS + CLK_NS - 1) / CLK_NS + 1;
  localparam int MAXC   = (RD_CYC > WP_CYC) ? ((RD_CYC > TA_CYC) ? RD_CYC : TA_CYC)
                                            : ((WP_CYC > TA_CYC) ? WP_CYC : TA_CYC);
  localparam int CW     = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RD_WAIT, S_RD_CAP, S_WR_SETUP, S_WR_PULSE, S_WR_HOLD, S_TURN
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rvalid_q, after_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      after_rd <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          if (!req_write) begin
            st  <= S_RD_WAIT;
            cnt <= CW'(RD_CYC - 1);
          end else if (after_rd) begin
            st  <= S_TURN;
            cnt <= CW'(TA_CYC - 1);
          end else begin
            st <= S_WR_SETUP;
          end
        end
        S_RD_WAIT:
          if (cnt == '0) st <= S_RD_CAP;
          else cnt <= cnt - 1'b1;
        S_RD_CAP: begin
          rdata_q  <= sram_dq;
          rvalid_q <= 1'b1;
          after_rd <= 1'b1;
          st       <= S_IDLE;
        end
        S_TURN:
          if (cnt == '0) begin
            st       <= S_WR_SETUP;
            after_rd <= 1'b0;
          end else cnt <= cnt - 1'b1;
        S_WR_SETUP: begin
          st  <= S_WR_PULSE;
          cnt <= CW'(WP_CYC - 1);
        end
        S_WR_PULSE:
          if (cnt == '0) st <= S_WR_HOLD;
          else cnt <= cnt - 1'b1;
        S_WR_HOLD: st <= S_IDLE;
        default:   st <= S_IDLE;
      endcase
    end
  end

  wire rd_on = (st == S_RD_WAIT) || (st == S_RD_CAP);
  wire wr_on = (st == S_WR_SETUP) || (st == S_WR_PULSE) || (st == S_WR_HOLD);

  assign req_ready  = (st == S_IDLE);
  assign sram_ce1_n = !(rd_on || wr_on);
  assign sram_ce2   = rd_on || wr_on;
  assign sram_oe_n  = !rd_on;
  assign sram_we_n  = (st != S_WR_PULSE);
  assign sram_addr  = addr_q;
  assign sram_dq    = wr_on ? wdata_q : {DW{1'bz}};
  assign rsp_valid  = rvalid_q;
  assign rsp_rdata  = rdata_q;
endmodule

module asram_ctrl_chk #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          ce1_n,
  input logic          ce2,
  input logic          we_n,
  input logic          oe_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] dq
);
  p_read_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce1_n && ce2 && we_n));

  p_write_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce1_n && ce2 && oe_n));

  p_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> ($past(!ce1_n) && $stable(addr) && $stable(dq)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (!ce1_n && $stable(addr) && $stable(dq)));

  p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce1_n && oe_n && we_n));
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .ce1_n(sram_ce1_n), .ce2(sram_ce2), .we_n(sram_we_n),
  .oe_n(sram_oe_n), .addr(sram_addr), .dq(sram_dq)
);

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;
  localparam int CLK_NS = 4;
  localparam int GRADE  = 10;
  localparam int RD     = (GRADE + CLK_NS - 1) / CLK_NS + 1;
  localparam int WP     = RD;
  localparam int TA     = (6 + CLK_NS - 1) / CLK_NS + 1;
  localparam int NEED   = (GRADE + CLK_NS - 1) / CLK_NS;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic [16:0] sram_addr;
  logic ce1_n, ce2, we_n, oe_n;
  wire  [7:0] sram_dq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] shadow [int];

  always #2 clk = ~clk;

  asram_ctrl #(.CLK_NS(CLK_NS), .GRADE_NS(GRADE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_ce1_n(ce1_n), .sram_ce2(ce2), .sram_we_n(we_n), .sram_oe_n(oe_n),
    .sram_dq(sram_dq)
  );

  // memory model: 64 tagged slots, garbage until access time has elapsed
  logic [7:0]  mem [64];
  logic [10:0] tag [64];
  logic [7:0]  rd_out;
  int age = 0;
  wire m_sel = !ce1_n && ce2;
  wire m_drv = m_sel && !oe_n && we_n;

  initial for (int i = 0; i < 64; i++) begin mem[i] = '0; tag[i] = '0; end

  always @(posedge clk) age <= m_drv ? age + 1 : 0;

  always_comb begin
    rd_out = (tag[sram_addr[5:0]] == sram_addr[16:6]) ? mem[sram_addr[5:0]] : 8'h00;
    if (age < NEED) rd_out = 8'hEE;
  end

  assign sram_dq = m_drv ? rd_out : 8'hzz;

  always @(posedge we_n) if (m_sel) begin
    mem[sram_addr[5:0]] = sram_dq;
    tag[sram_addr[5:0]] = sram_addr[16:6];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // protocol monitor
  logic pwe = 1, poe = 1, pce1 = 1;
  logic [16:0] paddr = '0;
  logic [7:0]  pdq = '0;
  int oe_run = 0, we_run = 0, gap = 0;
  bit gap_armed = 0;

  always @(negedge clk) if (rst_n) begin
    if (gap_armed) begin
      if (!oe_n) gap_armed = 0;
      else if (ce1_n) gap++;
      else begin check(gap >= TA + 1, "R6 turnaround gap", gap, TA + 1); gap_armed = 0; end
    end
    if (!oe_n) begin
      if (poe) check(!ce1_n && ce2 && we_n, "R2 read strobes", {ce1_n, ce2, we_n}, 3'b011);
      oe_run++;
    end else if (!poe) begin
      check(oe_run == RD + 1, "R2 oe length", oe_run, RD + 1);
      oe_run = 0; gap = 1; gap_armed = 1;
    end
    if (!we_n) begin
      if (pwe) begin
        check(!pce1 && sram_addr == paddr && sram_dq == pdq, "R5 setup", sram_addr, paddr);
        check(oe_n && ce2 && !ce1_n, "R4 strobes in pulse", {oe_n, ce2, ce1_n}, 3'b110);
      end
      we_run++;
    end else if (!pwe) begin
      check(we_run == WP, "R4 pulse length", we_run, WP);
      check(!ce1_n && sram_addr == paddr && sram_dq == pdq, "R5 hold", sram_addr, paddr);
      we_run = 0;
    end
    pwe = we_n; poe = oe_n; pce1 = ce1_n; paddr = sram_addr; pdq = sram_dq;
  end

  task automatic issue(input logic wr, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset;
    check(req_ready && !rsp_valid, "R1 ready/valid", {req_ready, rsp_valid}, 2'b10);
    check(ce1_n && !ce2 && we_n && oe_n, "R1 strobes", {ce1_n, ce2, we_n, oe_n}, 4'b1011);
  endtask

  task automatic t_write(input logic [16:0] a, input logic [7:0] d, input bit turn);
    int n = 0;
    bit stray = 0;
    issue(1, a, d);
    shadow[int'(a)] = d;
    check(!req_ready, "R8 busy after accept", req_ready, 0);
    if (turn) check(ce1_n, "R6 no select during turnaround", ce1_n, 1);
    else      check(!ce1_n, "R7 immediate select", ce1_n, 0);
    while (!req_ready && n < 100) begin
      if (rsp_valid) stray = 1;
      @(negedge clk); n++;
    end
    check(n == WP + 2 + (turn ? TA : 0), "R8 write occupancy", n, WP + 2 + (turn ? TA : 0));
    check(!stray, "R3 no rsp_valid on write", stray, 0);
  endtask

  task automatic t_read(input logic [16:0] a);
    int n = 0;
    logic [7:0] exp = shadow[int'(a)];
    issue(0, a, 8'h00);
    check(!req_ready, "R8 busy after accept", req_ready, 0);
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    check(n == RD + 1, "R3 latency", n, RD + 1);
    check(rsp_rdata == exp, "R3 data", rsp_rdata, exp);
    check(req_ready, "R8 ready at response", req_ready, 1);
    @(negedge clk);
    check(!rsp_valid, "R3 single pulse", rsp_valid, 0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write(17'h00000, 8'h5A, 0);
    t_write(17'h1FFFF, 8'hA5, 0);
    t_read(17'h00000);
    t_read(17'h1FFFF);
    t_write(17'h00123, 8'h3C, 1);
    t_read(17'h00123);
    t_write(17'h0ABCD, 8'hC3, 1);
    t_write(17'h0ABCD, 8'h0F, 0);
    for (int i = 1; i <= 8; i++)
      t_write(17'h10000 | 17'(i << 6) | 17'(i), 8'(i * 37) ^ 8'h5A, 0);
    for (int i = 1; i <= 8; i++)
      t_read(17'h10000 | 17'(i << 6) | 17'(i));
    t_read(17'h0ABCD);
    t_read(17'h1FFFF);
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule